// File: doc/BRIEF.md
# Temperature Sensor Scan Sequencer

This block decides which temperature sensor an external converter measures next. It steps through the sensor channels in ascending order and wraps back to the start. Channel 0 is the internal junction sensor and channel 1 is the remote diode. Any channel whose enable bit is clear is passed over. For each conversion the block raises a one-cycle start pulse together with the chosen channel number. It then holds that channel until the converter returns a one-cycle done pulse.

Scanning needs no trigger. It runs for as long as the function enable is set and device shutdown is clear. When either condition fails, the outstanding conversion is abandoned. A device reset does the same. Scanning then begins again from the lowest-numbered enabled sensor. In low-power mode the block adds a fixed idle gap after every conversion, which lowers the conversion rate.

Top module: `scan_seq`

## Requirements
- R1: While `rst` is high, `conv_start_o` is 0 and `conv_chan_o` is 0.
- R2: `conv_start_o` is high for exactly one cycle per conversion. `conv_chan_o` does not change until the next start pulse, and no new start is issued before `conv_done_i` is seen.
- R3: With sensor enables `sens_en_i` = 2'b11 (bit n enables channel n), successive conversions select channels 0, 1, 0, 1 in that order.
- R4: A channel whose `sens_en_i` bit is 0 is never selected. With only bit 1 set, every start selects channel 1. With only bit 0 set, every start selects channel 0.
- R5: When the block comes out of reset with the function running and sensors enabled, the first start appears in the first cycle after `rst` falls. That start selects the lowest enabled channel.
- R6: When low-power mode is off, a done pulse in cycle c produces the next start pulse in cycle c+1.
- R7: When `low_power_i` is 1, a done pulse in cycle c produces the next start in cycle c+1+LP_GAP. The start stays low for all LP_GAP cycles in between, and a done pulse that arrives during this gap is ignored.
- R8: When every `sens_en_i` bit is 0, no start is issued. When an enable is set again, the scan resumes from the channel after the last one converted.
- R9: No start is issued while `shutdown_i` is 1 or `func_en_i` is 0. Any outstanding conversion is dropped. When the block resumes, the next start selects the lowest enabled channel, one cycle after resume.
- R10: A one-cycle `dev_rst_i` pulse drops the current conversion. Two cycles after the pulse, the block starts the lowest enabled channel.
- R11: A done pulse that arrives while no conversion is outstanding produces no start and does not change the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_rst_i | input | 1 | Device reset pulse; restarts the scan |
| func_en_i | input | 1 | Function enable |
| shutdown_i | input | 1 | Device shutdown |
| low_power_i | input | 1 | Low-power mode; inserts the idle gap |
| sens_en_i | input | NUM_SENS | Per-sensor enable, bit n = channel n |
| conv_done_i | input | 1 | Converter done pulse |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_chan_o | output | CH_W | Channel of the current conversion |

## Verification
The start output and the channel output are both registered. As a result, a done pulse in active mode shows up as a start in the next cycle. A change in enable or run state also reaches the start output in the next cycle. A device reset takes two cycles, and a low-power done takes LP_GAP+1 cycles. The bench drives its inputs on the falling edge and samples the outputs on a later falling edge. It counts falling edges from each stimulus to the cycle in which the result is due. In the same way, it checks that the start output stays low in every cycle where nothing is due.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/scan_pick.sv
// Finds the next enabled channel after base, searching in ascending order with wrap.
// When from_low is set, the search starts at channel 0.
module scan_pick #(
  parameter int NUM_SENS = 2,
  parameter int CH_W     = 1
) (
  input  logic [NUM_SENS-1:0] en,
  input  logic [CH_W-1:0]     cur,
  input  logic                from_low,
  output logic [CH_W-1:0]     nxt,
  output logic                found
);
  int base;
  int cand;

  always_comb begin
    base  = from_low ? (NUM_SENS - 1) : int'(cur);
    found = 1'b0;
    nxt   = '0;
    cand  = 0;
    // Search from the farthest candidate down to the nearest, so the nearest hit wins.
    for (int i = NUM_SENS; i >= 1; i--) begin
      cand = base + i;
      if (cand >= NUM_SENS) cand = cand - NUM_SENS;
      if (en[cand]) begin
        found = 1'b1;
        nxt   = CH_W'(cand);
      end
    end
  end
endmodule

// File: rtl/scan_gap_timer.sv
// Counts the idle gap used in low-power mode.
module scan_gap_timer #(
  parameter int GAP = 8,
  parameter int W   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= W'(GAP - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int NUM_SENS = 2,
  parameter int LP_GAP   = 8,
  localparam int CH_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int GAP_W   = $clog2(LP_GAP + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_rst_i,
  input  logic                func_en_i,
  input  logic                shutdown_i,
  input  logic                low_power_i,
  input  logic [NUM_SENS-1:0] sens_en_i,
  input  logic                conv_done_i,
  output logic                conv_start_o,
  output logic [CH_W-1:0]     conv_chan_o
);
  sq_state_t       state_q, state_d;
  logic            restart_q, restart_d;
  logic            start_d;
  logic [CH_W-1:0] chan_d;
  logic [CH_W-1:0] pick_chan;
  logic            pick_ok;
  logic            gap_load;
  logic            gap_done;
  logic            run;

  assign run = func_en_i & ~shutdown_i;

  scan_pick #(.NUM_SENS(NUM_SENS), .CH_W(CH_W)) i_pick (
    .en       (sens_en_i),
    .cur      (conv_chan_o),
    .from_low (restart_q),
    .nxt      (pick_chan),
    .found    (pick_ok)
  );

  scan_gap_timer #(.GAP(LP_GAP), .W(GAP_W)) i_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .expired (gap_done)
  );

  always_comb begin
    state_d   = state_q;
    restart_d = restart_q;
    start_d   = 1'b0;
    chan_d    = conv_chan_o;
    gap_load  = 1'b0;
    if (!run || dev_rst_i) begin
      state_d   = SQ_IDLE;
      restart_d = 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (pick_ok) begin
            start_d   = 1'b1;
            chan_d    = pick_chan;
            restart_d = 1'b0;
            state_d   = SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (conv_done_i) begin
            if (low_power_i) begin
              gap_load = 1'b1;
              state_d  = SQ_GAP;
            end else if (pick_ok) begin
              start_d = 1'b1;
              chan_d  = pick_chan;
            end else begin
              state_d = SQ_IDLE;
            end
          end
        end
        SQ_GAP: begin
          if (gap_done) begin
            if (pick_ok) begin
              start_d = 1'b1;
              chan_d  = pick_chan;
              state_d = SQ_WAIT;
            end else begin
              state_d = SQ_IDLE;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SQ_IDLE;
      restart_q    <= 1'b1;
      conv_start_o <= 1'b0;
      conv_chan_o  <= '0;
    end else begin
      state_q      <= state_d;
      restart_q    <= restart_d;
      conv_start_o <= start_d;
      conv_chan_o  <= chan_d;
    end
  end
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NUM_SENS = 2,
  parameter int CH_W     = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                dev_rst_i,
  input logic                func_en_i,
  input logic                shutdown_i,
  input logic [NUM_SENS-1:0] sens_en_i,
  input logic                conv_done_i,
  input logic                conv_start_o,
  input logic [CH_W-1:0]     conv_chan_o
);
  logic [NUM_SENS-1:0] en_q;
  always_ff @(posedge clk) en_q <= sens_en_i;

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o && !conv_done_i |=> !conv_start_o);

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_start_o |-> $stable(conv_chan_o));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> $past(func_en_i && !shutdown_i && !dev_rst_i));

  // R4
  start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> en_q[conv_chan_o]);
endmodule

bind scan_seq scan_seq_chk #(.NUM_SENS(NUM_SENS), .CH_W(CH_W)) i_scan_seq_chk (
  .clk          (clk),
  .rst          (rst),
  .dev_rst_i    (dev_rst_i),
  .func_en_i    (func_en_i),
  .shutdown_i   (shutdown_i),
  .sens_en_i    (sens_en_i),
  .conv_done_i  (conv_done_i),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o)
);

// File: tb/test_scan_seq.sv
module test_scan_seq;
  localparam int N   = 2;
  localparam int GAP = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dev_rst = 1'b0;
  logic         func_en = 1'b1;
  logic         shutdown = 1'b0;
  logic         low_power = 1'b0;
  logic [N-1:0] sens_en = 2'b11;
  logic         done = 1'b0;
  logic         start;
  logic [0:0]   chan;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scan_seq #(.NUM_SENS(N), .LP_GAP(GAP)) i_scan_seq (
    .clk          (clk),
    .rst          (rst),
    .dev_rst_i    (dev_rst),
    .func_en_i    (func_en),
    .shutdown_i   (shutdown),
    .low_power_i  (low_power),
    .sens_en_i    (sens_en),
    .conv_done_i  (done),
    .conv_start_o (start),
    .conv_chan_o  (chan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_start(input string req, input int exp);
    chk(int'(start) == exp, req, int'(start), exp);
  endtask

  task automatic chk_chan(input string req, input int exp);
    chk(int'(chan) == exp, req, int'(chan), exp);
  endtask

  task automatic pulse_done;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_start(req, 0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk_start("R1 start in reset", 0);
    chk_chan("R1 chan in reset", 0);
    rst = 1'b0;
    @(negedge clk);
    chk_start("R5 first start", 1);
    chk_chan("R5 first chan", 0);
  endtask

  task automatic t_pulse;
    quiet(6, "R2 single pulse, no start before done");
    chk_chan("R2 chan held", 0);
  endtask

  task automatic t_rr;
    for (int k = 0; k < 4; k++) begin
      pulse_done;
      chk_start("R6 start one cycle after done", 1);
      chk_chan("R3 ascending wrap", (k % 2 == 0) ? 1 : 0);
      quiet(2, "R2 no extra start");
    end
  endtask

  task automatic t_devrst;
    dev_rst = 1'b1;
    @(negedge clk);
    dev_rst = 1'b0;
    chk_start("R10 no start during device reset", 0);
    @(negedge clk);
    chk_start("R10 restart start", 1);
    chk_chan("R10 restart from lowest", 0);
    @(negedge clk);
  endtask

  task automatic t_off;
    shutdown = 1'b1;
    @(negedge clk);
    pulse_done;
    chk_start("R9 no start in shutdown", 0);
    quiet(5, "R9 shutdown quiet");
    shutdown = 1'b0;
    @(negedge clk);
    chk_start("R9 resume after shutdown", 1);
    chk_chan("R9 resume lowest", 0);
    func_en = 1'b0;
    @(negedge clk);
    pulse_done;
    chk_start("R9 no start with function disabled", 0);
    quiet(5, "R9 disabled quiet");
    func_en = 1'b1;
    @(negedge clk);
    chk_start("R9 resume after enable", 1);
    chk_chan("R9 resume lowest after enable", 0);
    @(negedge clk);
  endtask

  task automatic t_skip;
    sens_en = 2'b10;
    for (int k = 0; k < 3; k++) begin
      pulse_done;
      chk_start("R4 start with only ch1", 1);
      chk_chan("R4 skip ch0", 1);
      @(negedge clk);
    end
    sens_en = 2'b01;
    for (int k = 0; k < 2; k++) begin
      pulse_done;
      chk_start("R4 start with only ch0", 1);
      chk_chan("R4 skip ch1", 0);
      @(negedge clk);
    end
  endtask

  task automatic t_lp;
    sens_en   = 2'b11;
    low_power = 1'b1;
    pulse_done;
    for (int k = 1; k <= GAP; k++) begin
      chk_start("R7 idle gap", 0);
      done = (k == 2);
      @(negedge clk);
    end
    done = 1'b0;
    chk_start("R7 start after gap", 1);
    chk_chan("R7 next chan after gap", 1);
    low_power = 1'b0;
    quiet(1, "R11 done in gap ignored");
  endtask

  task automatic t_none;
    sens_en = 2'b00;
    pulse_done;
    chk_start("R8 no start without enables", 0);
    quiet(8, "R8 idle quiet");
    pulse_done;
    chk_start("R11 stray done ignored", 0);
    chk_chan("R11 chan unchanged", 1);
    quiet(3, "R11 stray done quiet");
    sens_en = 2'b11;
    @(negedge clk);
    chk_start("R8 resume on enable", 1);
    chk_chan("R8 resume after last", 0);
  endtask

  initial begin
    t_reset;
    t_pulse;
    t_rr;
    t_devrst;
    t_off;
    t_skip;
    t_lp;
    t_none;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule